// File: doc/BRIEF.md
# Clocked Serial Slave Receiver

This block receives words from an external master over a clocked serial link. The master drives the serial clock. The block oversamples that clock with its own system clock, finds each rising edge, and takes one data bit at each edge. Bits arrive most significant first. Each finished word moves into a holding register, and a one-cycle completion pulse goes out for each word.

A host controls the block through level inputs and two strobes. The level inputs are power enable, receive enable, continuation enable and a length selector. The strobes are a read of the receive register and a clear of the busy flag. Reception does not start on its own. The host must first read the receive register once, as a dummy read, to arm it. The busy flag then rises and the block waits for clock edges. While continuation stays set, the block takes word after word with no further reads. If continuation is low when a word completes, the block stops and drops busy. Clearing continuation part-way through a word therefore still lets that word finish. The busy clear strobe abandons a partial word at once.

Top module: `sslv_rx`

## Requirements
- R1: After reset, `rx_data` is 0 and `busy` and `rx_done` are 0.
- R2: Words are assembled most significant bit first and right-aligned in `rx_data`, with the unused upper bits 0.
  - Each bit is the level of `sdi` while `sck` rises.
  - The word length is 8 + `len_sel` bits, capped at the maximum width, so a `len_sel` of 0 gives 8 bits.
- R3: Arming and the idle state:
  - A one-cycle `rd_strobe` while both enables are 1 and `busy` is 0 sets `busy` on the next cycle.
  - Serial clock edges while `busy` is 0 change neither `rx_data` nor `rx_done`.
- R4: Completion timing:
  - `rx_done` is high for exactly one cycle per finished word.
  - `rx_data` takes the new word in the same cycle that `rx_done` goes high, and changes at no other time.
  - `rx_done` goes high on the third system clock edge after the `sck` rise that carries the last bit.
- R5: With `cont_en` at 1, `busy` stays 1 after a word completes, and the next edges form the next word without another `rd_strobe`.
- R6: With `cont_en` at 0 when a word completes, `busy` falls together with `rx_done`. Clearing `cont_en` part-way through a word still lets that word finish and be delivered.
- R7: A `busy_clr` pulse does three things:
  - It drops `busy` on the next cycle and discards the partial word with no `rx_done`.
  - It takes priority over a `rd_strobe` in the same cycle.
  - The next armed word starts from an empty shifter.
- R8: While `pwr_en` or `rx_en` is 0:
  - `busy` is forced to 0, and the shifter and bit count are cleared.
  - `rd_strobe` does not arm the block, and no `rx_done` is produced.
  - `rx_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_en | input | 1 | Power enable; 0 holds the receive logic idle |
| rx_en | input | 1 | Receive enable; 0 holds the receive logic idle |
| cont_en | input | 1 | Continuation enable; 1 keeps receiving word after word |
| len_sel | input | LEN_W (4) | Word length minus 8 |
| rd_strobe | input | 1 | One-cycle read of the receive register; arms reception when idle |
| busy_clr | input | 1 | One-cycle software clear of the busy flag; aborts a partial word |
| sck | input | 1 | External serial clock, asynchronous |
| sdi | input | 1 | Serial data, sampled on the rising edge of sck |
| rx_data | output | MAX_BITS (16) | Last completed word, right-aligned |
| rx_done | output | 1 | One-cycle pulse per completed word |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest case is a change of control in the middle of a word. This covers clearing continuation after some bits have arrived, and also a busy clear or a power drop with a partial word in the shifter. To reach these cases, the stimulus sends a word in two bursts of serial clocks and changes the control input in the quiet gap between the bursts. After an abort, it arms the block again with a fresh word. If the word comes back clean, no leftover bits from the abandoned partial word leaked into it. A behavioural model follows every system clock, so a word that ends one cycle late is caught, and so is a stray completion pulse.

// File: rtl/sslv_rx_pkg.sv
// Package: shared types for the serial slave receiver.
// Assumes: nothing beyond the two-state control encoding below.
package sslv_rx_pkg;

    // Receive control state: idle waiting for a dummy read, or receiving.
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RECV = 1'b1
    } rx_state_e;

    // Smallest word the length selector can pick.
    localparam int MIN_BITS = 8;

endpackage

// File: rtl/sslv_rx_sync.sv
// Module: sslv_rx_sync
// Brings the asynchronous serial clock and data into the system clock
// domain and flags each rising edge of the serial clock.
// Assumes: the system clock runs at least four times the serial clock, and
// the data is stable around each serial clock rise. The data path has the
// same depth as the clock path, so the bit handed out belongs to the edge.
module sslv_rx_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic sdi,
    output logic sck_rise,
    output logic sdi_bit
);

    logic [SYNC_STAGES:0]   sck_pipe;
    logic [SYNC_STAGES-1:0] sdi_pipe;

    // Shift the raw inputs through the synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            sdi_pipe <= '0;
        end else begin
            sck_pipe <= {sck_pipe[SYNC_STAGES-1:0], sck};
            sdi_pipe <= {sdi_pipe[SYNC_STAGES-2:0], sdi};
        end
    end

    // Edge detect on the settled serial clock; the data bit has the same delay.
    always_comb begin
        sck_rise = sck_pipe[SYNC_STAGES-1] & ~sck_pipe[SYNC_STAGES];
        sdi_bit  = sdi_pipe[SYNC_STAGES-1];
    end

endmodule

// File: rtl/sslv_rx_shift.sv
// Module: sslv_rx_shift
// Assembles a word most significant bit first and counts its bits. When the
// last bit arrives it flags the word as finished and presents the full word
// on word_out in the same cycle. It then empties itself for the next word.
// Assumes: len_sel stays stable while a word is in progress.
module sslv_rx_shift
    import sslv_rx_pkg::*;
#(
    parameter int MAX_BITS = 16,
    localparam int LEN_W   = $clog2(MAX_BITS - MIN_BITS + 1),
    localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                shift_en,
    input  logic                bit_in,
    input  logic [LEN_W-1:0]    len_sel,
    output logic                word_done,
    output logic [MAX_BITS-1:0] word_out
);

    logic [MAX_BITS-2:0] sreg;
    logic [CNT_W-1:0]    cnt;
    logic                last_bit;
    int                  wlen;

    // Decode the selected word length, capped at the register width.
    always_comb begin
        wlen = MIN_BITS + int'(len_sel);
        if (wlen > MAX_BITS) begin
            wlen = MAX_BITS;
        end
        last_bit  = (int'(cnt) == wlen - 1);
        word_done = shift_en & last_bit;
        word_out  = {sreg, bit_in};
    end

    // Shift one bit per enabled edge; empty the shifter at a word end or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (shift_en) begin
            if (last_bit) begin
                sreg <= '0;
                cnt  <= '0;
            end else begin
                sreg <= word_out[MAX_BITS-2:0];
                cnt  <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sslv_rx_ctrl.sv
// Module: sslv_rx_ctrl
// Holds the busy state. A dummy read arms reception. The busy clear strobe
// or a dropped enable ends it at once. A word finishing with continuation
// low ends it after that word.
// Assumes: busy_clr takes priority over rd_strobe in the same cycle.
module sslv_rx_ctrl
    import sslv_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rd_strobe,
    input  logic busy_clr,
    input  logic cont_en,
    input  logic sck_rise,
    input  logic word_done,
    output logic busy,
    output logic shift_en,
    output logic clear
);

    rx_state_e state_q;
    rx_state_e state_d;

    // Next-state selection with priority: disable, abort, stop, arm.
    always_comb begin
        state_d = state_q;
        if (!active || busy_clr) begin
            state_d = RX_IDLE;
        end else if (state_q == RX_RECV && word_done && !cont_en) begin
            state_d = RX_IDLE;
        end else if (state_q == RX_IDLE && rd_strobe) begin
            state_d = RX_RECV;
        end
    end

    // Register the control state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Derive the shifter controls from the state and the enables.
    always_comb begin
        busy     = (state_q == RX_RECV);
        shift_en = busy & active & sck_rise & ~busy_clr;
        clear    = ~busy | ~active | busy_clr;
    end

endmodule

// File: rtl/sslv_rx.sv
// Module: sslv_rx (top)
// Clocked serial slave receiver. It synchronizes the external serial
// clock, shifts in words most significant bit first under the control
// state, and latches each finished word into a holding register together
// with a one-cycle completion pulse.
// Assumes: clk is at least four times the serial clock rate; MAX_BITS >= 9.
module sslv_rx
    import sslv_rx_pkg::*;
#(
    parameter int MAX_BITS    = 16,
    parameter int SYNC_STAGES = 2,
    localparam int LEN_W      = $clog2(MAX_BITS - MIN_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_en,
    input  logic                rx_en,
    input  logic                cont_en,
    input  logic [LEN_W-1:0]    len_sel,
    input  logic                rd_strobe,
    input  logic                busy_clr,
    input  logic                sck,
    input  logic                sdi,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_done,
    output logic                busy
);

    logic                sck_rise;
    logic                sdi_bit;
    logic                shift_en;
    logic                clear;
    logic                word_done;
    logic [MAX_BITS-1:0] word_out;
    logic                active;

    // Both enables must be set for the receive logic to run.
    always_comb active = pwr_en & rx_en;

    sslv_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sdi      (sdi),
        .sck_rise (sck_rise),
        .sdi_bit  (sdi_bit)
    );

    sslv_rx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .rd_strobe (rd_strobe),
        .busy_clr  (busy_clr),
        .cont_en   (cont_en),
        .sck_rise  (sck_rise),
        .word_done (word_done),
        .busy      (busy),
        .shift_en  (shift_en),
        .clear     (clear)
    );

    sslv_rx_shift #(.MAX_BITS(MAX_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .shift_en  (shift_en),
        .bit_in    (sdi_bit),
        .len_sel   (len_sel),
        .word_done (word_done),
        .word_out  (word_out)
    );

    // Latch a finished word and pulse completion for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= word_done;
            if (word_done) begin
                rx_data <= word_out;
            end
        end
    end

endmodule

// File: rtl/sslv_rx_chk.sv
// Module: sslv_rx_chk
// Protocol checks on the receiver ports, attached to every sslv_rx instance.
// Assumes: synchronous active-low reset; all checks are off during reset.
module sslv_rx_chk #(
    parameter int MAX_BITS = 16,
    parameter int LEN_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pwr_en,
    input logic                rx_en,
    input logic                cont_en,
    input logic [LEN_W-1:0]    len_sel,
    input logic                rd_strobe,
    input logic                busy_clr,
    input logic [MAX_BITS-1:0] rx_data,
    input logic                rx_done,
    input logic                busy
);

    // R4: completion lasts exactly one cycle.
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R4: the holding register moves only with a completion pulse.
    assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> $stable(rx_data));

    // R4: a word can only complete while busy.
    assert_done_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(busy));

    // R3: a dummy read while idle and enabled arms the receiver.
    assert_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && pwr_en && rx_en && !busy && !busy_clr) |=> busy);

    // R5: with continuation set, busy survives a completed word.
    assert_cont_keeps_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && $past(cont_en)) |-> busy);

    // R6: with continuation clear, busy drops with the completion pulse.
    assert_stop_after_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !$past(cont_en)) |-> !busy);

    // R7: a busy clear ends reception with no completion.
    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_clr |=> (!busy && !rx_done));

    // R8: a dropped enable forces idle and suppresses completion.
    assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_en && rx_en) |=> (!busy && !rx_done));

endmodule

bind sslv_rx sslv_rx_chk #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_en    (pwr_en),
    .rx_en     (rx_en),
    .cont_en   (cont_en),
    .len_sel   (len_sel),
    .rd_strobe (rd_strobe),
    .busy_clr  (busy_clr),
    .rx_data   (rx_data),
    .rx_done   (rx_done),
    .busy      (busy)
);

// File: tb/sslv_rx_tb.sv
// Bench for sslv_rx: a behavioural model runs on every system clock and is
// compared with the ports each cycle, plus scenario checks per requirement.
module sslv_rx_tb;

    localparam int MAXB = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwr_en = 1'b0, rx_en = 1'b0, cont_en = 1'b0;
    logic [3:0]      len_sel = '0;
    logic            rd_strobe = 1'b0, busy_clr = 1'b0;
    logic            sck = 1'b0, sdi = 1'b0;
    logic [MAXB-1:0] rx_data;
    logic            rx_done;
    logic            busy;

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;
    int done_cnt = 0, run = 0, max_run = 0;

    // Model state.
    int              m_busy, m_cnt, m_word, m_done;
    logic [MAXB-1:0] m_data;
    int              h_sck[4], h_sdi[4];

    always #2 clk = ~clk;

    sslv_rx #(.MAX_BITS(MAXB)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .rx_en(rx_en),
        .cont_en(cont_en), .len_sel(len_sel), .rd_strobe(rd_strobe),
        .busy_clr(busy_clr), .sck(sck), .sdi(sdi),
        .rx_data(rx_data), .rx_done(rx_done), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model: edge seen two clocks late, bit taken with it.
    always @(posedge clk) begin
        int rise, bitv, wlen;
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_word = 0; m_done = 0; m_data = '0;
            for (int i = 0; i < 4; i++) begin h_sck[i] = 0; h_sdi[i] = 0; end
        end else begin
            for (int i = 3; i > 0; i--) begin h_sck[i] = h_sck[i-1]; h_sdi[i] = h_sdi[i-1]; end
            h_sck[0] = int'(sck); h_sdi[0] = int'(sdi);
            rise = (h_sck[2] == 1 && h_sck[3] == 0) ? 1 : 0;
            bitv = h_sdi[2];
            m_done = 0;
            if (!(pwr_en && rx_en) || busy_clr) begin
                m_busy = 0; m_cnt = 0; m_word = 0;
            end else if (m_busy == 0) begin
                m_cnt = 0; m_word = 0;
                if (rd_strobe) m_busy = 1;
            end else if (rise == 1) begin
                m_word = m_word * 2 + bitv;
                m_cnt++;
                wlen = 8 + int'(len_sel);
                if (wlen > MAXB) wlen = MAXB;
                if (m_cnt == wlen) begin
                    m_data = MAXB'(m_word);
                    m_done = 1; m_cnt = 0; m_word = 0;
                    if (!cont_en) m_busy = 0;
                end
            end
        end
    end

    // Per-cycle comparison and pulse bookkeeping, away from the edge.
    always @(posedge clk) begin
        #1;
        if (cmp_on && !finished) begin
            chk(rx_data == m_data, "R2 rx_data vs model", rx_data, m_data);
            chk(rx_done == m_done[0], "R4 rx_done vs model", rx_done, m_done);
            chk(busy == m_busy[0], "R3 busy vs model", busy, m_busy);
            if (rx_done) begin
                done_cnt++; run++;
                if (run > max_run) max_run = run;
            end else begin
                run = 0;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int val, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = val[i]; sck = 1'b0; tick(3);
            sck = 1'b1; tick(3);
        end
        sck = 1'b0; tick(4);
    endtask

    task automatic pulse_rd();
        rd_strobe = 1'b1; tick(1); rd_strobe = 1'b0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int d0;
        tick(4); rst_n = 1'b1; tick(1); cmp_on = 1'b1;
        chk(rx_data == 0 && !busy && !rx_done, "R1 reset state", {rx_data, busy, rx_done}, 0);

        pwr_en = 1'b1; rx_en = 1'b1;
        send(8'hFF, 8);
        chk(done_cnt == 0, "R3 unarmed edges ignored", done_cnt, 0);
        chk(rx_data == 0, "R3 unarmed data unchanged", rx_data, 0);

        pulse_rd();
        chk(busy == 1'b1, "R3 dummy read arms", busy, 1);
        send(8'hA5, 8);
        chk(rx_data == 16'h00A5, "R2 8-bit MSB first", rx_data, 16'h00A5);
        chk(done_cnt == 1, "R4 one completion", done_cnt, 1);
        chk(busy == 1'b0, "R6 stops after word", busy, 0);

        cont_en = 1'b1; len_sel = 4'd4;
        pulse_rd();
        send(12'hABC, 12);
        chk(rx_data == 16'h0ABC, "R2 12-bit word", rx_data, 16'h0ABC);
        chk(busy == 1'b1, "R5 busy kept in continuous", busy, 1);
        send(12'h123, 12);
        chk(rx_data == 16'h0123, "R5 second word without read", rx_data, 16'h0123);
        send(6'h16, 6);
        cont_en = 1'b0;
        send(6'h23, 6);
        chk(rx_data == 16'h05A3, "R6 word finishes after cont clear", rx_data, 16'h05A3);
        chk(busy == 1'b0, "R6 busy drops", busy, 0);
        chk(done_cnt == 4, "R5 completion count", done_cnt, 4);

        len_sel = 4'd8;
        pulse_rd();
        send(16'hC3E1, 16);
        chk(rx_data == 16'hC3E1, "R2 16-bit word", rx_data, 16'hC3E1);

        len_sel = 4'd0;
        pulse_rd();
        d0 = done_cnt;
        send(5'h1F, 5);
        busy_clr = 1'b1; rd_strobe = 1'b1; tick(1); busy_clr = 1'b0; rd_strobe = 1'b0;
        chk(busy == 1'b0, "R7 clear beats read", busy, 0);
        chk(done_cnt == d0, "R7 no completion on abort", done_cnt, d0);
        pulse_rd();
        send(8'h3C, 8);
        chk(rx_data == 16'h003C, "R7 fresh word after abort", rx_data, 16'h003C);

        pulse_rd();
        send(4'hF, 4);
        pwr_en = 1'b0; tick(1);
        chk(busy == 1'b0, "R8 power off clears busy", busy, 0);
        pulse_rd(); tick(1);
        chk(busy == 1'b0, "R8 read ignored while off", busy, 0);
        d0 = done_cnt;
        send(8'h99, 8);
        chk(done_cnt == d0, "R8 no completion while off", done_cnt, d0);
        chk(rx_data == 16'h003C, "R8 data held while off", rx_data, 16'h003C);
        pwr_en = 1'b1; rx_en = 1'b0;
        pulse_rd(); tick(1);
        chk(busy == 1'b0, "R8 read ignored with rx_en low", busy, 0);
        rx_en = 1'b1;
        pulse_rd();
        send(8'h81, 8);
        chk(rx_data == 16'h0081, "R8 partial word discarded", rx_data, 16'h0081);
        chk(max_run == 1, "R4 pulse width one cycle", max_run, 1);

        tick(4);
        report();
    end

endmodule